// File: doc/BRIEF.md
# I/Q Sample FIFO with Ready Threshold

This block buffers complex baseband samples, 16-bit I and Q pairs, between a data source and a downstream filter that pulls one pair at a time on request. It holds up to seven pairs. The source is either a serial deserializer, which presents a full pair with a one-cycle strobe, or a host register port. On the host port the Q half is written first and is held. The later write of the I half pushes the complete pair. A mode input chooses which of the two sources is active. Writes from the other source are ignored.

The consumer raises a read request for each pair it needs. Pairs come out oldest first on a registered output, valid from the cycle after the request. If the buffer is empty, or the block is set off-line, the consumer receives zeros instead of stored data. A ready flag tells the source to supply more data while the fill level is below a programmed 3-bit threshold.

A push into a full buffer is an error. By default the error soft-resets the channel: the level, the storage, the output pair and the held Q half are cleared together, and a one-cycle soft-reset pulse is raised. A control input can disable this reset. With the reset disabled, the offending pair is dropped and nothing else changes. The host can read back the most recently accepted pair at any time.

Top module: `iq_sample_fifo`

## Requirements
- R1: The buffer holds at most 7 pairs. Read requests return the accepted pairs, and a read request beyond those returns zeros.
- R2: The fill level rises by one on each accepted push without a read, and falls by one on each read request without a push while the buffer is non-empty. The level is observable through `ready`.
- R3: In host mode (`src_par`=1), a write to `host_addr`=1 stores the Q half. A following write to `host_addr`=0 pushes the pair, made of the written data as I and the stored Q half as Q.
- R4: With `src_par`=0 only `ser_push` pushes, and host writes to address 0 do not. With `src_par`=1 only host writes to address 0 push, and `ser_push` is ignored. A host write to address 1 while `src_par`=0 does not change the stored Q half.
- R5: A read request while the buffer is empty makes `out_i` and `out_q` zero on the following cycle.
- R6: A read request while `online`=0 makes the output pair zero on the following cycle. It still consumes the oldest stored pair.
- R7: A push into a full buffer without a read in the same cycle is an error. With `full_rst_dis`=0 the error raises `soft_rst` for exactly the next cycle. With `full_rst_dis`=1 the pair is dropped, `soft_rst` stays low and the contents are kept.
- R8: `ready` is 1 exactly when the fill level is less than `depth_thr`.
- R9: `last_i`/`last_q` show the most recently accepted pair. They are zero after reset.
- R10: A push and a read request in the same cycle on a non-empty buffer leave the level unchanged, and the output takes the oldest pair. On an empty buffer the output is zero and the new pair is kept, so the level becomes one.
- R11: The asynchronous reset and the soft reset both clear the level, the stored pairs, the output pair, the readback and the held Q half in one cycle.
- R12: Pairs leave in the order they were accepted. Each read request updates the output on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_par | input | 1 | Source select: 0 serial strobe, 1 host register port |
| ser_push | input | 1 | Serial source: one-cycle strobe that pushes a pair |
| ser_i | input | 16 | Serial source I sample |
| ser_q | input | 16 | Serial source Q sample |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_addr | input | 1 | Host register select: 0 I half (push), 1 Q half |
| host_data | input | 16 | Host write data |
| online | input | 1 | 1 delivers stored data, 0 delivers zeros |
| full_rst_dis | input | 1 | 1 disables the soft reset on a push into a full buffer |
| depth_thr | input | 3 | Ready threshold on the fill level |
| rd_req | input | 1 | Consumer read request, one cycle per pair |
| out_i | output | 16 | I sample delivered to the consumer |
| out_q | output | 16 | Q sample delivered to the consumer |
| ready | output | 1 | High while the fill level is below the threshold |
| soft_rst | output | 1 | One-cycle pulse after a full-buffer push error |
| last_i | output | 16 | Readback: I half of the most recent accepted pair |
| last_q | output | 16 | Readback: Q half of the most recent accepted pair |

## Verification
The assertions assume that the strobes are sampled as single-cycle events, that a host write carries one address per cycle, and that `src_par` changes only in cycles without a pending write. The stimulus keeps to these by driving every strobe for exactly one clock and switching mode only while idle. The bench applies full-buffer pushes with and without a same-cycle read, reads while empty and while off-line, and sweeps the threshold. A behavioural queue model tracks the expected output pair, the readback and the ready flag in every cycle.

// File: rtl/iqf_pkg.sv
package iqf_pkg;
   typedef enum logic {
      SRC_SERIAL = 1'b0,
      SRC_HOST   = 1'b1
   } src_e;

   localparam logic HOST_REG_I = 1'b0;
   localparam logic HOST_REG_Q = 1'b1;
endpackage

// File: rtl/iqf_src_sel.sv
module iqf_src_sel #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          src_par,
   input  logic          ser_push,
   input  logic [DW-1:0] ser_i,
   input  logic [DW-1:0] ser_q,
   input  logic          host_wr,
   input  logic          host_addr,
   input  logic [DW-1:0] host_data,
   output logic          push,
   output logic [DW-1:0] push_i,
   output logic [DW-1:0] push_q
);
   import iqf_pkg::*;

   logic [DW-1:0] q_hold;
   logic          host_sel;

   assign host_sel = (src_e'(src_par) == SRC_HOST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_hold <= '0;
      end else if (clr) begin
         q_hold <= '0;
      end else if (host_sel && host_wr && host_addr == HOST_REG_Q) begin
         q_hold <= host_data;
      end
   end

   always_comb begin
      if (host_sel) begin
         push   = host_wr && (host_addr == HOST_REG_I);
         push_i = host_data;
         push_q = q_hold;
      end else begin
         push   = ser_push;
         push_i = ser_i;
         push_q = ser_q;
      end
   end
endmodule

// File: rtl/iqf_store.sv
module iqf_store #(
   parameter int DW    = 16,
   parameter int DEPTH = 7,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic          rd_req,
   input  logic [DW-1:0] push_i,
   input  logic [DW-1:0] push_q,
   output logic [CW-1:0] lvl,
   output logic          pop,
   output logic          err,
   output logic [DW-1:0] head_i,
   output logic [DW-1:0] head_q,
   output logic [DW-1:0] last_i,
   output logic [DW-1:0] last_q
);
   localparam logic [CW-1:0] FULL = CW'(DEPTH);
   localparam int            PW   = 2 * DW;

   logic [PW-1:0] ent [DEPTH];
   logic          accept;
   logic [PW-1:0] head;

   assign pop    = rd_req && (lvl != '0);
   assign err    = push && (lvl == FULL) && !pop;
   assign accept = push && !err;

   // Entry 0 always holds the newest pair; the oldest sits at index lvl-1.
   generate
      for (genvar k = 0; k < DEPTH; k++) begin : g_ent
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ent[k] <= '0;
            end else if (clr) begin
               ent[k] <= '0;
            end else if (accept) begin
               if (k == 0) ent[k] <= {push_i, push_q};
               else        ent[k] <= ent[(k == 0) ? 0 : k - 1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl <= '0;
      end else if (clr) begin
         lvl <= '0;
      end else if (accept && !pop) begin
         lvl <= lvl + 1'b1;
      end else if (pop && !accept) begin
         lvl <= lvl - 1'b1;
      end
   end

   always_comb begin
      head = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (lvl == CW'(k + 1)) head = ent[k];
      end
   end

   assign head_i = head[PW-1:DW];
   assign head_q = head[DW-1:0];
   assign last_i = ent[0][PW-1:DW];
   assign last_q = ent[0][DW-1:0];
endmodule

// File: rtl/iqf_out.sv
module iqf_out #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          rd_req,
   input  logic          pop,
   input  logic          online,
   input  logic [DW-1:0] head_i,
   input  logic [DW-1:0] head_q,
   output logic [DW-1:0] out_i,
   output logic [DW-1:0] out_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_i <= '0;
         out_q <= '0;
      end else if (clr) begin
         out_i <= '0;
         out_q <= '0;
      end else if (rd_req) begin
         if (pop && online) begin
            out_i <= head_i;
            out_q <= head_q;
         end else begin
            out_i <= '0;
            out_q <= '0;
         end
      end
   end
endmodule

// File: rtl/iq_sample_fifo.sv
module iq_sample_fifo #(
   parameter int DW    = 16,
   parameter int DEPTH = 7,
   parameter int TW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          src_par,
   input  logic          ser_push,
   input  logic [DW-1:0] ser_i,
   input  logic [DW-1:0] ser_q,
   input  logic          host_wr,
   input  logic          host_addr,
   input  logic [DW-1:0] host_data,
   input  logic          online,
   input  logic          full_rst_dis,
   input  logic [TW-1:0] depth_thr,
   input  logic          rd_req,
   output logic [DW-1:0] out_i,
   output logic [DW-1:0] out_q,
   output logic          ready,
   output logic          soft_rst,
   output logic [DW-1:0] last_i,
   output logic [DW-1:0] last_q
);
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("iq_sample_fifo: DEPTH must be at least 2");
      end
      if (TW < CW) begin : g_bad_thr
         $error("iq_sample_fifo: threshold narrower than the fill level");
      end
      if (DW < 1) begin : g_bad_dw
         $error("iq_sample_fifo: DW must be positive");
      end
   endgenerate

   logic          push;
   logic [DW-1:0] push_i, push_q;
   logic [CW-1:0] fill_lvl;
   logic          pop, err, clr;
   logic [DW-1:0] head_i, head_q;

   assign clr = err && !full_rst_dis;

   iqf_src_sel #(.DW(DW)) u_src (
      .clk(clk), .rst_n(rst_n), .clr(clr), .src_par(src_par),
      .ser_push(ser_push), .ser_i(ser_i), .ser_q(ser_q),
      .host_wr(host_wr), .host_addr(host_addr), .host_data(host_data),
      .push(push), .push_i(push_i), .push_q(push_q)
   );

   iqf_store #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_store (
      .clk(clk), .rst_n(rst_n), .clr(clr), .push(push), .rd_req(rd_req),
      .push_i(push_i), .push_q(push_q), .lvl(fill_lvl), .pop(pop), .err(err),
      .head_i(head_i), .head_q(head_q), .last_i(last_i), .last_q(last_q)
   );

   iqf_out #(.DW(DW)) u_out (
      .clk(clk), .rst_n(rst_n), .clr(clr), .rd_req(rd_req), .pop(pop),
      .online(online), .head_i(head_i), .head_q(head_q),
      .out_i(out_i), .out_q(out_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) soft_rst <= 1'b0;
      else        soft_rst <= clr;
   end

   assign ready = TW'(fill_lvl) < depth_thr;
endmodule

// File: rtl/iq_sample_fifo_chk.sv
module iq_sample_fifo_chk #(
   parameter int DW    = 16,
   parameter int DEPTH = 7
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           src_par,
   input logic                           ser_push,
   input logic                           host_wr,
   input logic                           host_addr,
   input logic                           online,
   input logic                           full_rst_dis,
   input logic                           rd_req,
   input logic [DW-1:0]                  out_i,
   input logic [DW-1:0]                  out_q,
   input logic                           soft_rst,
   input logic [$clog2(DEPTH + 1)-1:0]   lvl
);
   localparam int            CW   = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   logic push_any;
   assign push_any = src_par ? (host_wr && !host_addr) : ser_push;

   AST_LVL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      lvl <= FULL); // R1
   AST_LVL_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (push_any && !rd_req && lvl != FULL) |=> lvl == CW'($past(lvl) + 1'b1)); // R2
   AST_LVL_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (!push_any && rd_req && lvl != '0) |=> lvl == CW'($past(lvl) - 1'b1)); // R2
   AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && lvl == '0) |=> (out_i == '0 && out_q == '0)); // R5
   AST_OFFLINE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !online) |=> (out_i == '0 && out_q == '0)); // R6
   AST_FULL_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (push_any && !rd_req && lvl == FULL && !full_rst_dis) |=> (soft_rst && lvl == '0)); // R7
   AST_FULL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (push_any && !rd_req && lvl == FULL && full_rst_dis) |=> (!soft_rst && lvl == FULL)); // R7
   AST_SAME_LVL: assert property (@(posedge clk) disable iff (!rst_n)
      (push_any && rd_req && lvl != '0) |=> $stable(lvl)); // R10
endmodule

bind iq_sample_fifo iq_sample_fifo_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .src_par(src_par), .ser_push(ser_push),
   .host_wr(host_wr), .host_addr(host_addr), .online(online),
   .full_rst_dis(full_rst_dis), .rd_req(rd_req), .out_i(out_i),
   .out_q(out_q), .soft_rst(soft_rst), .lvl(fill_lvl)
);

// File: tb/sim_iq_sample_fifo.sv
`timescale 1ns/1ps
module sim_iq_sample_fifo;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        src_par = 1'b0, ser_push = 1'b0, host_wr = 1'b0, host_addr = 1'b0;
   logic [15:0] ser_i = '0, ser_q = '0, host_data = '0;
   logic        online = 1'b1, full_rst_dis = 1'b0, rd_req = 1'b0;
   logic [2:0]  depth_thr = 3'd4;
   logic [15:0] out_i, out_q, last_i, last_q;
   logic        ready, soft_rst;

   int checks = 0, errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   iq_sample_fifo u0 (
      .clk(clk), .rst_n(rst_n), .src_par(src_par), .ser_push(ser_push),
      .ser_i(ser_i), .ser_q(ser_q), .host_wr(host_wr), .host_addr(host_addr),
      .host_data(host_data), .online(online), .full_rst_dis(full_rst_dis),
      .depth_thr(depth_thr), .rd_req(rd_req), .out_i(out_i), .out_q(out_q),
      .ready(ready), .soft_rst(soft_rst), .last_i(last_i), .last_q(last_q)
   );

   // Behavioural reference model
   logic [31:0] mq[$];
   logic [15:0] m_oi = '0, m_oq = '0, m_li = '0, m_lq = '0, m_qh = '0;
   bit          m_srst = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mq.delete();
         m_oi = '0; m_oq = '0; m_li = '0; m_lq = '0; m_qh = '0; m_srst = 0;
      end else begin
         bit          push, popv, errv;
         logic [31:0] np, fr;
         push = src_par ? (host_wr && host_addr == 1'b0) : ser_push;
         np   = src_par ? {host_data, m_qh} : {ser_i, ser_q};
         popv = rd_req && mq.size() > 0;
         errv = push && mq.size() == 7 && !popv;
         m_srst = 0;
         if (errv && !full_rst_dis) begin
            mq.delete();
            m_oi = '0; m_oq = '0; m_li = '0; m_lq = '0; m_qh = '0; m_srst = 1;
         end else begin
            if (src_par && host_wr && host_addr == 1'b1) m_qh = host_data;
            if (rd_req) begin
               if (popv) begin
                  fr = mq.pop_front();
                  if (online) begin m_oi = fr[31:16]; m_oq = fr[15:0]; end
                  else        begin m_oi = '0;        m_oq = '0;       end
               end else begin
                  m_oi = '0; m_oq = '0;
               end
            end
            if (push && !errv) begin
               mq.push_back(np);
               m_li = np[31:16]; m_lq = np[15:0];
            end
         end
      end
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         chk("R12 out_i", out_i, m_oi);
         chk("R12 out_q", out_q, m_oq);
         chk("R9 last_i", last_i, m_li);
         chk("R9 last_q", last_q, m_lq);
         chk("R8 ready", ready, (mq.size() < depth_thr) ? 1 : 0);
         chk("R7 soft_rst", soft_rst, m_srst ? 1 : 0);
      end
   end

   task automatic step();
      @(posedge clk); #5;
      ser_push = 0; host_wr = 0; rd_req = 0;
   endtask
   task automatic spush(input logic [15:0] i, input logic [15:0] q);
      ser_i = i; ser_q = q; ser_push = 1; step();
   endtask
   task automatic hwr(input logic a, input logic [15:0] d);
      host_addr = a; host_data = d; host_wr = 1; step();
   endtask
   task automatic rd();
      rd_req = 1; step();
   endtask
   task automatic hpair(input logic [15:0] i, input logic [15:0] q);
      hwr(1'b1, q); hwr(1'b0, i);
   endtask

   initial begin
      #(20 * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #5 rst_n = 1;
      step();
      // R11: reset state
      chk("R11 out_i", out_i, 0);
      chk("R11 last_i", last_i, 0);
      chk("R11 ready", ready, 1);
      chk("R11 soft_rst", soft_rst, 0);

      // serial source
      for (int k = 1; k <= 3; k++) spush(16'h1000 + 16'(k), 16'h2000 + 16'(k));
      chk("R8 ready level3 thr4", ready, 1);
      spush(16'h1004, 16'h2004);
      chk("R8 ready level4 thr4", ready, 0);
      rd(); chk("R12 first out", out_i, 16'h1001); chk("R12 first q", out_q, 16'h2001);
      rd(); chk("R12 second out", out_i, 16'h1002);
      chk("R2 level down", ready, 1);

      // host source
      src_par = 1;
      ser_i = 16'h1777; ser_q = 16'h2777; ser_push = 1;
      hwr(1'b1, 16'h2AAA);
      chk("R4 serial ignored in host mode", last_i, 16'h1004);
      hwr(1'b0, 16'h1AAA);
      chk("R3 pair pushed i", last_i, 16'h1AAA);
      chk("R3 pair pushed q", last_q, 16'h2AAA);
      step(); src_par = 0; step();
      hwr(1'b0, 16'h1BBB);
      chk("R4 host ignored in serial mode", last_i, 16'h1AAA);
      hwr(1'b1, 16'h2BAD);
      step(); src_par = 1; step();
      hwr(1'b0, 16'h1ABC);
      chk("R4 q hold untouched in serial mode", last_q, 16'h2AAA);

      // fill to 7 (level now 4)
      depth_thr = 3'd7;
      hpair(16'h1005, 16'h2005);
      hpair(16'h1006, 16'h2006);
      chk("R8 ready level6 thr7", ready, 1);
      hpair(16'h1007, 16'h2007);
      chk("R8 ready level7 thr7", ready, 0);

      // full push with reset disabled
      full_rst_dis = 1;
      hpair(16'h1EEE, 16'h2EEE);
      chk("R7 no soft reset when disabled", soft_rst, 0);
      chk("R7 dropped pair", last_i, 16'h1007);

      // simultaneous read and write at full
      rd_req = 1; hwr(1'b0, 16'h1FFF);
      chk("R10 out oldest", out_i, 16'h1003);
      chk("R10 push accepted", last_i, 16'h1FFF);
      chk("R10 level kept", ready, 0);

      // full push with reset enabled
      full_rst_dis = 0;
      hwr(1'b0, 16'h1CCC);
      chk("R7 soft reset pulse", soft_rst, 1);
      chk("R11 cleared last", last_i, 0);
      chk("R11 cleared out", out_i, 0);
      chk("R11 cleared level", ready, 1);
      step();
      chk("R7 pulse one cycle", soft_rst, 0);

      // empty reads
      hwr(1'b0, 16'h1000);
      chk("R11 q hold cleared", last_q, 0);
      rd();
      hpair(16'h1212, 16'h2121);
      rd(); chk("R12 single", out_i, 16'h1212);
      rd(); chk("R5 empty zero i", out_i, 0); chk("R5 empty zero q", out_q, 0);
      rd_req = 1; hwr(1'b0, 16'h1313);
      chk("R10 empty read zero", out_i, 0);
      rd(); chk("R10 empty write kept", out_i, 16'h1313); chk("R10 q", out_q, 16'h2121);

      // off-line
      hwr(1'b0, 16'h1414);
      hwr(1'b0, 16'h1415);
      online = 0; rd(); chk("R6 offline zero", out_i, 0);
      online = 1; rd(); chk("R6 offline consumed", out_i, 16'h1415);

      // capacity
      full_rst_dis = 1;
      for (int k = 0; k < 8; k++) hwr(1'b0, 16'h1500 + 16'(k));
      for (int k = 0; k < 8; k++) begin
         rd();
         chk("R1 capacity", out_i, (k < 7) ? (16'h1500 + k) : 0);
      end

      // threshold sweep
      depth_thr = 3'd0; step();
      chk("R8 thr0", ready, 0);
      depth_thr = 3'd2;
      hwr(1'b0, 16'h1600); hwr(1'b0, 16'h1601);
      chk("R2 level2 thr2", ready, 0);
      rd(); chk("R2 level1 thr2", ready, 1);
      step();

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule